// File: doc/BRIEF.md
# Output Port with Atomic Bit Set and Clear

This block is a 16-pin general-purpose output port. A 16-bit output latch drives the pins directly. Software changes the latch over a small memory-mapped register interface: address, write enable, write data, read enable and read data. There are three ways to change the latch. A plain data word replaces all 16 bits. A combined 32-bit word sets some bits and clears others. A 16-bit word only clears bits.

The combined word and the clear-only word let software change any chosen group of pins in a single bus write. Software does not need a read-modify-write sequence, so an interrupt that arrives in the middle cannot corrupt the port state. Every bit that one write changes moves on the same clock edge. If a combined write asks to both raise and lower the same pin, the pin goes high.

The register offsets are fixed:

| Offset | Name | Access |
|--------|------|--------|
| 0x0 | Data word | Read and write |
| 0x4 | Combined set/clear word | Write only |
| 0x8 | Clear-only word | Write only |

Top module: `gpio_drive_port`

## Requirements
- R1: A write to offset 0x0 loads `wr_data[15:0]` into the output latch on the next rising edge. A read of offset 0x0 returns the stored value in `rd_data[15:0]` one cycle after `rd_en`, with zeros in `rd_data[31:16]`.
- R2: A write to offset 0x4 raises every output bit n whose `wr_data[n]` is 1, for n in 0..15.
- R3: A write to offset 0x4 lowers output bit n whenever `wr_data[n+16]` is 1 and `wr_data[n]` is 0.
- R4: A write to offset 0x8 lowers every output bit n whose `wr_data[n]` is 1. Bits `wr_data[31:16]` of this write have no effect.
- R5: When one write to offset 0x4 has both `wr_data[n]` and `wr_data[n+16]` at 1, bit n ends high.
- R6: All bits that a single write changes, whether raised or lowered, change on the same rising edge. There is no intermediate pin pattern.
- R7: An output bit that a write to offset 0x4 or 0x8 does not select keeps its previous value.
- R8: A read of offset 0x4, offset 0x8 or any unmapped offset returns zero. `rd_data` is zero in any cycle after one with `rd_en` low.
- R9: A synchronous active-high `rst` clears the output latch and `rd_data` to zero.
- R10: A write to any offset other than 0x0, 0x4 or 0x8 leaves the pins unchanged. `wr_data[31:16]` of a write to offset 0x0 is ignored.
- R11: A read and a write in the same cycle return the value held before that write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| pins | output | 16 | Output drive vector, taken straight from the latch |

## Verification
The bench aims at the following corner cases:

- **Same bit raised and lowered in one combined write.** A design that gave priority to the clear would leave the pin low.
- **Raise and lower in one write.** Bit 7 is raised while bit 6 is lowered. A design that applied the two halves on different edges would show a stray pattern for one cycle. The per-cycle model compares the pins on every clock, so it catches that pattern.
- **Ignored inputs.**
  - The upper half of a clear-only write. A design that decoded it would drop pins.
  - The upper half of a data write.
  - Writes to unmapped offsets. A design that aliased them onto a real register would corrupt the pins.
- **Read during a write.** A read in the same cycle as a write must return the old value. A design that forwarded the new value would break R11.
- **Reads of the write-only words.** These must return zero. A design that returned latch data would break R8.

// File: rtl/gpio_drive_port.sv
module gpio_drive_port #(
  parameter int PINS = 16,
  parameter int AW = 4,
  parameter logic [AW-1:0] OFS_DATA = 4'h0,
  parameter logic [AW-1:0] OFS_SETCLR = 4'h4,
  parameter logic [AW-1:0] OFS_CLR = 4'h8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [2*PINS-1:0] wr_data,
  input  logic            rd_en,
  output logic [2*PINS-1:0] rd_data,
  output logic [PINS-1:0] pins
);
  localparam int WORD = 2 * PINS;

  logic [PINS-1:0] out_q, out_d, set_m, clr_m;
  logic hit_data, hit_sc, hit_clr;

  assign hit_data = wr_en && (addr == OFS_DATA);
  assign hit_sc   = wr_en && (addr == OFS_SETCLR);
  assign hit_clr  = wr_en && (addr == OFS_CLR);

  assign set_m = wr_data[PINS-1:0];
  assign clr_m = wr_data[WORD-1:PINS];

  always_comb begin
    out_d = out_q;
    if (hit_data)
      out_d = wr_data[PINS-1:0];
    else if (hit_sc)
      out_d = (out_q & ~clr_m) | set_m;
    else if (hit_clr)
      out_d = out_q & ~wr_data[PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      rd_data <= '0;
    end else begin
      out_q   <= out_d;
      rd_data <= (rd_en && addr == OFS_DATA) ? {{PINS{1'b0}}, out_q} : '0;
    end
  end

  assign pins = out_q;

  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETCLR) |=> ((pins & $past(wr_data[PINS-1:0])) == $past(wr_data[PINS-1:0]))); // R2
  AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETCLR) |=> ((pins & $past(wr_data[WORD-1:PINS]) & ~$past(wr_data[PINS-1:0])) == '0)); // R3
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLR) |=> ((pins & $past(wr_data[PINS-1:0])) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETCLR && (wr_data[PINS-1:0] & wr_data[WORD-1:PINS]) != '0)
      |=> ((pins & $past(wr_data[PINS-1:0] & wr_data[WORD-1:PINS])) == $past(wr_data[PINS-1:0] & wr_data[WORD-1:PINS]))); // R5
  AST_SC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETCLR)
      |=> (((pins ^ $past(pins)) & ~($past(wr_data[PINS-1:0]) | $past(wr_data[WORD-1:PINS]))) == '0)); // R7
  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLR) |=> (((pins ^ $past(pins)) & ~$past(wr_data[PINS-1:0])) == '0)); // R7
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (addr != OFS_DATA && addr != OFS_SETCLR && addr != OFS_CLR)) |=> $stable(pins)); // R10
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || addr != OFS_DATA) |=> (rd_data == '0)); // R8
  AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_DATA) |=> (rd_data == {{PINS{1'b0}}, $past(pins)})); // R11
endmodule

// File: tb/sim_gpio_drive_port.sv
module sim_gpio_drive_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [15:0] pins;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R9";
  logic [15:0] exp_pins = '0;
  logic [31:0] exp_rd = '0;

  always #5 clk = ~clk;

  gpio_drive_port u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pins(pins)
  );

  always @(posedge clk) begin
    if (rst) begin
      exp_pins = '0;
      exp_rd = '0;
    end else begin
      exp_rd = (rd_en && addr == 4'h0) ? {16'h0, exp_pins} : 32'h0;
      if (wr_en) begin
        case (addr)
          4'h0: exp_pins = wr_data[15:0];
          4'h4: for (int i = 0; i < 16; i++) begin
                  if (wr_data[i]) exp_pins[i] = 1'b1;
                  else if (wr_data[i+16]) exp_pins[i] = 1'b0;
                end
          4'h8: for (int i = 0; i < 16; i++)
                  if (wr_data[i]) exp_pins[i] = 1'b0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk({cur_req, " model pins"}, {16'h0, pins}, {16'h0, exp_pins});
    chk({cur_req, " model rd_data"}, rd_data, exp_rd);
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    cur_req = req; addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk);
    cur_req = req; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset pins", {16'h0, pins}, 32'h0);
    chk("R9 reset rd_data", rd_data, 32'h0);
    rst = 1'b0;
    wr(4'h0, 32'h0000A5C3, "R1");
    chk("R1 data load", {16'h0, pins}, 32'hA5C3);
    rd(4'h0, "R1");
    chk("R1 data read", rd_data, 32'h0000A5C3);
    wr(4'h0, 32'hFFFF1234, "R10");
    chk("R10 upper data half ignored", {16'h0, pins}, 32'h1234);
    wr(4'hC, 32'hFFFFFFFF, "R10");
    wr(4'h2, 32'h00000000, "R10");
    chk("R10 unmapped write ignored", {16'h0, pins}, 32'h1234);
    wr(4'h4, 32'h00000F00, "R2");
    chk("R2 set bits", {16'h0, pins}, 32'h1F34);
    wr(4'h4, 32'h00300000, "R3");
    chk("R3 clear bits", {16'h0, pins}, 32'h1F04);
    wr(4'h4, 32'h00000040, "R2");
    wr(4'h4, 32'h00400080, "R6");
    chk("R6 raise 7 lower 6 together", {16'h0, pins}, 32'h1F84);
    wr(4'h4, 32'hFFFF00AA, "R5");
    chk("R5 set wins over clear", {16'h0, pins}, 32'h00AA);
    wr(4'h0, 32'h0000C3FF, "R1");
    wr(4'h4, 32'h00A3005C, "R7");
    chk("R7 high byte kept", {16'h0, pins}, 32'hC35C);
    wr(4'h8, 32'hFFFF0F0C, "R4");
    chk("R4 clear-only word", {16'h0, pins}, 32'hC050);
    wr(4'h8, 32'hFFFF0000, "R4");
    chk("R4 upper half no effect", {16'h0, pins}, 32'hC050);
    rd(4'h4, "R8");
    chk("R8 setclr reads zero", rd_data, 32'h0);
    rd(4'h8, "R8");
    chk("R8 clear word reads zero", rd_data, 32'h0);
    @(negedge clk);
    cur_req = "R11"; addr = 4'h0; wr_data = 32'h00007777; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read returns old value", rd_data, 32'h0000C050);
    chk("R11 write landed", {16'h0, pins}, 32'h7777);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cur_req = "R6";
      addr = 4'($urandom_range(0, 3) * 4);
      wr_data = $urandom;
      wr_en = $urandom_range(0, 3) != 0;
      rd_en = $urandom_range(0, 1) != 0;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    cur_req = "R9";
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset after traffic", {16'h0, pins}, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule